// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits behind the strobe pins of an asynchronous NOR-style flash part and turns byte writes on the data bus into actions. A write is taken when write-enable rises while chip-enable is low. Depending on the command sequence, the block chooses what a read returns: array bytes, two identifier bytes, or a status byte. It also runs a small write state machine for block erase and byte program. Both operations can be paused and resumed, and both can be aborted by the reset/powerdown pin.

All strobes are sampled in one clock domain. The memory array is a behavioural stand-in with 64 bytes in four blocks of 16. Erase and program repeat one pulse per clock until the `verifyOk` input reports success or a pulse limit is reached. The data bus is split into `dataIn`, `dataOut` and an output-enable flag `dataOutEn` that stands in for the high-impedance state.

Top module: `flash_cmd_if`

## Requirements
- R1: After system reset the block is in array-read mode, every array byte reads FFH, and the status byte is 80H.
- R2: Command FFH selects array-read mode. The mode stays until another accepted command changes it.
- R3: After command 90H, a read at address 0 returns the maker code (default 5AH) and a read at address 1 returns the device code (default C3H).
- R4: After command 70H, reads return a status snapshot. The snapshot is taken on the first clock after the later of CE and OE goes low. It does not change while both stay low.
- R5: Command 40H followed by one address/data write programs that byte. The new value is the old value ANDed with the data. Status bit 7 (ready) reads 0 while busy and 1 again when the operation ends.
- R6: Command 20H followed by D0H erases the whole 16-byte block that holds the confirm address, setting it to FFH. Other blocks are untouched.
- R7: If `verifyOk` stays low for MAX_PULSES busy cycles, a failed erase sets status bit 5 and a failed program sets status bit 4. These bits stay set until command 50H clears them.
- R8: If 20H is followed by any byte other than D0H, status bits 5 and 4 are both set, nothing is erased, and reads return status.
- R9: Command B0H during erase or program suspends the operation. Status bit 7 reads 1, bit 6 reads 1 only for a suspended erase, and reads stay in status mode.
- R10: While suspended, FFH allows array reads. D0H resumes the operation, which then completes.
- R11: With `rpN` low, `dataOutEn` is 0. Afterwards the block is in array-read mode with status 80H. An erase or program in progress is aborted, and its block reads 00H until it is next erased.
- R12: With CE high, `dataOutEn` is 0, and a running operation still completes.
- R13: During a busy erase or program, any command other than B0H is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | System reset, active low |
| rpN | input | 1 | Reset/deep-powerdown pin, active low |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low; a write is taken on its rise |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Command or program data |
| verifyOk | input | 1 | Verify result for the current pulse |
| dataOut | output | 8 | Read data |
| dataOutEn | output | 1 | Read data driven (0 = high impedance) |

## Verification
A command takes effect on the clock edge where `weN` is first seen high after being low. A status snapshot appears on `dataOut` one clock after the strobes enable output. An operation with `verifyOk` high finishes on its first busy cycle, and a failing one finishes after MAX_PULSES busy cycles. The bench keeps a behavioural model that follows these same edge counts. It compares `dataOutEn` and `dataOut` three nanoseconds after every falling clock edge. Directed reads sample one full clock after the strobes fall. Waits for operations are longer than the worst-case pulse count.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    WS_IDLE, WS_ERASE_SETUP, WS_PROG_SETUP,
    WS_ERASE_BUSY, WS_PROG_BUSY, WS_ERASE_SUSP, WS_PROG_SUSP
  } wsmState_e;

  typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_STATUS} readMode_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_PROGRAM    = 8'h40;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;

  typedef struct packed {
    logic      wsmReady;
    logic      eraseSusp;
    logic      latchOp;
    logic      eraseDone;
    logic      progDone;
    logic      eraseFail;
    logic      progFail;
    logic      seqError;
    logic      clearStatus;
    logic      abort;
    readMode_e readMode;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int MAX_PULSES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rpN,
  input  logic       ceN,
  input  logic       weN,
  input  logic [7:0] dataIn,
  input  logic       verifyOk,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = $clog2(MAX_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(MAX_PULSES - 1);

  wsmState_e       state;
  readMode_e       mode;
  logic [CNT_W-1:0] pulseCnt;
  logic            weQ;
  logic            cmdWrite;
  logic            isBusy;
  logic            busyStep;
  logic            lastPulse;

  assign cmdWrite  = rpN && !ceN && weN && !weQ;
  assign isBusy    = (state == WS_ERASE_BUSY) || (state == WS_PROG_BUSY);
  assign busyStep  = rpN && isBusy && !(cmdWrite && dataIn == CMD_SUSPEND);
  assign lastPulse = (pulseCnt == LAST_PULSE);

  always_comb begin
    strobe             = '0;
    strobe.readMode    = mode;
    strobe.wsmReady    = !isBusy;
    strobe.eraseSusp   = (state == WS_ERASE_SUSP);
    strobe.abort       = !rpN && (isBusy || state == WS_ERASE_SUSP || state == WS_PROG_SUSP);
    strobe.clearStatus = cmdWrite && state == WS_IDLE && dataIn == CMD_CLEAR;
    strobe.seqError    = cmdWrite && state == WS_ERASE_SETUP && dataIn != CMD_CONFIRM;
    strobe.latchOp     = cmdWrite && ((state == WS_ERASE_SETUP && dataIn == CMD_CONFIRM)
                                      || state == WS_PROG_SETUP);
    strobe.eraseDone   = busyStep && state == WS_ERASE_BUSY && verifyOk;
    strobe.progDone    = busyStep && state == WS_PROG_BUSY && verifyOk;
    strobe.eraseFail   = busyStep && state == WS_ERASE_BUSY && !verifyOk && lastPulse;
    strobe.progFail    = busyStep && state == WS_PROG_BUSY && !verifyOk && lastPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= WS_IDLE;
      mode     <= RD_ARRAY;
      pulseCnt <= '0;
      weQ      <= 1'b1;
    end else begin
      weQ <= weN;
      if (!rpN) begin
        state    <= WS_IDLE;
        mode     <= RD_ARRAY;
        pulseCnt <= '0;
      end else begin
        unique case (state)
          WS_IDLE: if (cmdWrite) begin
            unique case (dataIn)
              CMD_READ_ARRAY: mode <= RD_ARRAY;
              CMD_IDENT:      mode <= RD_IDENT;
              CMD_STATUS:     mode <= RD_STATUS;
              CMD_ERASE:      begin state <= WS_ERASE_SETUP; mode <= RD_STATUS; end
              CMD_PROGRAM:    begin state <= WS_PROG_SETUP;  mode <= RD_STATUS; end
              default: ;
            endcase
          end
          WS_ERASE_SETUP: if (cmdWrite) begin
            pulseCnt <= '0;
            state    <= (dataIn == CMD_CONFIRM) ? WS_ERASE_BUSY : WS_IDLE;
          end
          WS_PROG_SETUP: if (cmdWrite) begin
            pulseCnt <= '0;
            state    <= WS_PROG_BUSY;
          end
          WS_ERASE_BUSY, WS_PROG_BUSY: begin
            if (cmdWrite && dataIn == CMD_SUSPEND)
              state <= (state == WS_ERASE_BUSY) ? WS_ERASE_SUSP : WS_PROG_SUSP;
            else if (verifyOk || lastPulse)
              state <= WS_IDLE;
            else
              pulseCnt <= pulseCnt + 1'b1;
          end
          WS_ERASE_SUSP, WS_PROG_SUSP: if (cmdWrite) begin
            unique case (dataIn)
              CMD_READ_ARRAY: mode <= RD_ARRAY;
              CMD_IDENT:      mode <= RD_IDENT;
              CMD_STATUS:     mode <= RD_STATUS;
              CMD_CONFIRM: begin
                mode  <= RD_STATUS;
                state <= (state == WS_ERASE_SUSP) ? WS_ERASE_BUSY : WS_PROG_BUSY;
              end
              default: ;
            endcase
          end
          default: state <= WS_IDLE;
        endcase
      end
    end
  end

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    isBusy |-> (pulseCnt < CNT_W'(MAX_PULSES))); // R7
  AST_ONE_END: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.eraseDone, strobe.progDone, strobe.eraseFail, strobe.progFail})); // R5
  AST_SUSPEND_READY: assert property (@(posedge clk) disable iff (!rstN)
    (rpN && isBusy && cmdWrite && dataIn == CMD_SUSPEND) |=> strobe.wsmReady); // R9
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         BLOCK_W  = 2,
  parameter logic [7:0] MFR_CODE = 8'h5A,
  parameter logic [7:0] DEV_CODE = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rpN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  ctlStrobe_t        strobe,
  output logic [7:0]        dataOut,
  output logic              dataOutEn
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NBLK  = 1 << BLOCK_W;
  localparam int OFF_W = ADDR_W - BLOCK_W;

  logic [7:0]        mem [DEPTH];
  logic [NBLK-1:0]   blkBad;
  logic              eraseStat, progStat;
  logic [7:0]        statusSnap;
  logic              enQ;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic              outEn;
  logic [7:0]        liveStatus;
  logic [BLOCK_W-1:0] opBlk, rdBlk;

  assign outEn      = !ceN && !oeN && rpN;
  assign dataOutEn  = outEn;
  assign liveStatus = {strobe.wsmReady, strobe.eraseSusp, eraseStat, progStat, 4'b0000};
  assign opBlk      = opAddr[ADDR_W-1:OFF_W];
  assign rdBlk      = addr[ADDR_W-1:OFF_W];

  always_comb begin
    unique case (strobe.readMode)
      RD_IDENT:  dataOut = (addr == '0) ? MFR_CODE :
                           (addr == ADDR_W'(1)) ? DEV_CODE : 8'h00;
      RD_STATUS: dataOut = statusSnap;
      default:   dataOut = blkBad[rdBlk] ? 8'h00 : mem[addr];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      blkBad     <= '0;
      eraseStat  <= 1'b0;
      progStat   <= 1'b0;
      statusSnap <= 8'h80;
      enQ        <= 1'b0;
      opAddr     <= '0;
      opData     <= '0;
    end else begin
      enQ <= outEn;
      if (!rpN) begin
        eraseStat  <= 1'b0;
        progStat   <= 1'b0;
        statusSnap <= 8'h80;
        if (strobe.abort) blkBad[opBlk] <= 1'b1;
      end else begin
        if (outEn && !enQ) statusSnap <= liveStatus;
        if (strobe.latchOp) begin
          opAddr <= addr;
          opData <= dataIn;
        end
        if (strobe.clearStatus) begin
          eraseStat <= 1'b0;
          progStat  <= 1'b0;
        end
        if (strobe.seqError) begin
          eraseStat <= 1'b1;
          progStat  <= 1'b1;
        end
        if (strobe.eraseFail) eraseStat <= 1'b1;
        if (strobe.progFail)  progStat  <= 1'b1;
        if (strobe.eraseDone) begin
          for (int i = 0; i < DEPTH; i++)
            if (i[ADDR_W-1:OFF_W] == opBlk) mem[i] <= 8'hFF;
          blkBad[opBlk] <= 1'b0;
        end
        if (strobe.progDone) mem[opAddr] <= mem[opAddr] & opData;
      end
    end
  end

  AST_RP_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> (liveStatus == 8'h80)); // R11
  AST_SEQ_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seqError |=> (eraseStat && progStat)); // R8
  AST_STICKY_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (eraseStat && rpN && !strobe.clearStatus) |=> eraseStat); // R7
  AST_ERASE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseDone |=> (mem[{opBlk, {OFF_W{1'b0}}}] == 8'hFF)); // R6
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W     = 6,
  parameter int         BLOCK_W    = 2,
  parameter int         MAX_PULSES = 16,
  parameter logic [7:0] MFR_CODE   = 8'h5A,
  parameter logic [7:0] DEV_CODE   = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rpN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              verifyOk,
  output logic [7:0]        dataOut,
  output logic              dataOutEn
);
  ctlStrobe_t strobe;

  flash_cmd_ctrl #(.MAX_PULSES(MAX_PULSES)) uCtrl (
    .clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .weN(weN),
    .dataIn(dataIn), .verifyOk(verifyOk), .strobe(strobe)
  );

  flash_cmd_dp #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W),
                 .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) uDp (
    .clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .strobe(strobe),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: tb/tb_flash_cmd_if.sv
module tb_flash_cmd_if;
  localparam int MAXP = 16;

  logic clk = 0, rstN = 0, rpN = 1, ceN = 1, oeN = 1, weN = 1, verifyOk = 1;
  logic [5:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOutEn;
  int nChecks = 0, nFails = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  flash_cmd_if dut (.clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .verifyOk(verifyOk), .dataOut(dataOut), .dataOutEn(dataOutEn));

  // Behavioural reference: st 0 idle,1 erase setup,2 prog setup,3 erase busy,4 prog busy,5 erase susp,6 prog susp
  // mode 0 array,1 ident,2 status
  byte unsigned mMem [64];
  bit   mBad [4];
  int   mSt, mMode, mCnt, mOpA;
  byte unsigned mOpD, mSnap;
  bit   mE, mP, mEnQ, mWeQ;

  always @(posedge clk) begin
    bit en, wr, rdy, busy;
    byte unsigned live;
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 8'hFF;
      foreach (mBad[i]) mBad[i] = 0;
      mSt = 0; mMode = 0; mCnt = 0; mOpA = 0; mOpD = 0;
      mE = 0; mP = 0; mSnap = 8'h80; mEnQ = 0; mWeQ = 1;
    end else begin
      en   = !ceN && !oeN && rpN;
      wr   = rpN && !ceN && weN && !mWeQ;
      busy = (mSt == 3 || mSt == 4);
      rdy  = !busy;
      live = {rdy, mSt == 5, mE, mP, 4'b0};
      if (!rpN) begin
        if (mSt >= 3) mBad[mOpA / 16] = 1;
        mSt = 0; mMode = 0; mE = 0; mP = 0; mSnap = 8'h80; mCnt = 0;
      end else begin
        if (en && !mEnQ) mSnap = live;
        case (mSt)
          0: if (wr) begin
            if (dataIn == 8'hFF) mMode = 0;
            else if (dataIn == 8'h90) mMode = 1;
            else if (dataIn == 8'h70) mMode = 2;
            else if (dataIn == 8'h50) begin mE = 0; mP = 0; end
            else if (dataIn == 8'h20) begin mSt = 1; mMode = 2; end
            else if (dataIn == 8'h40) begin mSt = 2; mMode = 2; end
          end
          1: if (wr) begin
            mCnt = 0;
            if (dataIn == 8'hD0) begin mSt = 3; mOpA = addr; end
            else begin mSt = 0; mE = 1; mP = 1; end
          end
          2: if (wr) begin mCnt = 0; mSt = 4; mOpA = addr; mOpD = dataIn; end
          3, 4: begin
            if (wr && dataIn == 8'hB0) mSt = mSt + 2;
            else if (verifyOk) begin
              if (mSt == 3) begin
                for (int i = 0; i < 16; i++) mMem[(mOpA / 16) * 16 + i] = 8'hFF;
                mBad[mOpA / 16] = 0;
              end else mMem[mOpA] = mMem[mOpA] & mOpD;
              mSt = 0;
            end else if (mCnt == MAXP - 1) begin
              if (mSt == 3) mE = 1; else mP = 1;
              mSt = 0;
            end else mCnt++;
          end
          default: if (wr) begin
            if (dataIn == 8'hFF) mMode = 0;
            else if (dataIn == 8'h90) mMode = 1;
            else if (dataIn == 8'h70) mMode = 2;
            else if (dataIn == 8'hD0) begin mMode = 2; mSt = mSt - 2; end
          end
        endcase
      end
      mEnQ = en;
      mWeQ = weN;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (rstN) begin
      bit expEn;
      byte unsigned expD;
      expEn = rpN && !ceN && !oeN;
      check({curReq, " model oe"}, int'(dataOutEn), int'(expEn));
      if (expEn) begin
        if (mMode == 1) expD = (addr == 0) ? 8'h5A : (addr == 1) ? 8'hC3 : 8'h00;
        else if (mMode == 2) expD = mSnap;
        else expD = mBad[addr / 16] ? 8'h00 : mMem[addr];
        check({curReq, " model data"}, int'(dataOut), int'(expD));
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrCmd(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); ceN = 0; weN = 0; addr = a; dataIn = d;
    @(negedge clk); weN = 1;
    @(negedge clk); ceN = 1;
  endtask

  task automatic rdChk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; ceN = 0; oeN = 0;
    @(negedge clk); #1;
    check(tag, int'(dataOut), int'(exp));
    check({tag, " en"}, int'(dataOutEn), 1);
    oeN = 1; ceN = 1;
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    cyc(3); rstN = 1; cyc(2);
    curReq = "R1";
    rdChk("R1 array after reset", 6'h00, 8'hFF);
    wrCmd(0, 8'h70); rdChk("R1 status after reset", 0, 8'h80);

    curReq = "R5";
    wrCmd(6'h05, 8'h40); wrCmd(6'h05, 8'h3C); cyc(3);
    rdChk("R5 ready after program", 0, 8'h80);
    curReq = "R2";
    wrCmd(0, 8'hFF); rdChk("R2 array read", 6'h05, 8'h3C);
    rdChk("R2 mode holds", 6'h06, 8'hFF);
    curReq = "R5";
    wrCmd(6'h05, 8'h40); wrCmd(6'h05, 8'hF0); cyc(3);
    wrCmd(0, 8'hFF); rdChk("R5 AND program", 6'h05, 8'h30);

    curReq = "R3";
    wrCmd(0, 8'h90);
    rdChk("R3 maker code", 6'h00, 8'h5A);
    rdChk("R3 device code", 6'h01, 8'hC3);

    curReq = "R4";
    verifyOk = 0;
    wrCmd(6'h10, 8'h20); wrCmd(6'h10, 8'hD0);
    @(negedge clk); ceN = 0; oeN = 0;
    @(negedge clk); #1 check("R4 busy snapshot", int'(dataOut), 8'h00);
    verifyOk = 1; cyc(3); #1;
    check("R4 snapshot held", int'(dataOut), 8'h00);
    oeN = 1; cyc(1); oeN = 0; cyc(1); #1;
    check("R4 snapshot after toggle", int'(dataOut), 8'h80);
    oeN = 1; ceN = 1;
    curReq = "R6";
    wrCmd(0, 8'hFF); rdChk("R6 other block untouched", 6'h05, 8'h30);
    wrCmd(6'h03, 8'h20); wrCmd(6'h03, 8'hD0); cyc(3);
    wrCmd(0, 8'hFF); rdChk("R6 block erased", 6'h05, 8'hFF);

    curReq = "R7";
    verifyOk = 0;
    wrCmd(6'h07, 8'h40); wrCmd(6'h07, 8'hAA); cyc(MAXP + 4);
    rdChk("R7 program fail", 0, 8'h90);
    wrCmd(0, 8'h70); rdChk("R7 sticky", 0, 8'h90);
    wrCmd(0, 8'h50); rdChk("R7 cleared", 0, 8'h80);
    wrCmd(6'h08, 8'h20); wrCmd(6'h08, 8'hD0); cyc(MAXP + 4);
    rdChk("R7 erase fail", 0, 8'hA0);
    wrCmd(0, 8'h50); verifyOk = 1;

    curReq = "R8";
    wrCmd(6'h05, 8'h40); wrCmd(6'h05, 8'h0F); cyc(3);
    wrCmd(6'h00, 8'h20); wrCmd(6'h00, 8'hFF); cyc(2);
    rdChk("R8 sequence error", 0, 8'hB0);
    wrCmd(0, 8'h50); wrCmd(0, 8'hFF);
    rdChk("R8 no erase", 6'h05, 8'h0F);

    curReq = "R9";
    wrCmd(6'h21, 8'h40); wrCmd(6'h21, 8'h12); cyc(3);
    verifyOk = 0;
    wrCmd(6'h20, 8'h20); wrCmd(6'h20, 8'hD0); wrCmd(0, 8'hB0);
    rdChk("R9 erase suspended", 0, 8'hC0);
    curReq = "R10";
    wrCmd(0, 8'hFF); rdChk("R10 array during suspend", 6'h05, 8'h0F);
    verifyOk = 1; wrCmd(0, 8'hD0); cyc(3);
    rdChk("R10 resumed done", 0, 8'h80);
    wrCmd(0, 8'hFF); rdChk("R10 resumed erase applied", 6'h21, 8'hFF);
    curReq = "R9";
    verifyOk = 0;
    wrCmd(6'h22, 8'h40); wrCmd(6'h22, 8'h55); wrCmd(0, 8'hB0);
    rdChk("R9 program suspended", 0, 8'h80);
    verifyOk = 1; wrCmd(0, 8'hD0); cyc(3);
    curReq = "R10";
    wrCmd(0, 8'hFF); rdChk("R10 program resumed", 6'h22, 8'h55);

    curReq = "R13";
    verifyOk = 0;
    wrCmd(6'h30, 8'h20); wrCmd(6'h30, 8'hD0); wrCmd(0, 8'h90);
    rdChk("R13 ident ignored while busy", 6'h00, 8'h00);
    verifyOk = 1; cyc(3);

    curReq = "R12";
    verifyOk = 0;
    wrCmd(6'h31, 8'h40); wrCmd(6'h31, 8'h66);
    @(negedge clk); oeN = 0; ceN = 1;
    @(negedge clk); #1 check("R12 standby hiz", int'(dataOutEn), 0);
    verifyOk = 1; cyc(3); oeN = 1;
    wrCmd(0, 8'hFF); rdChk("R12 op completed", 6'h31, 8'h66);

    curReq = "R11";
    verifyOk = 0;
    wrCmd(6'h32, 8'h40); wrCmd(6'h32, 8'h77);
    @(negedge clk); rpN = 0; ceN = 0; oeN = 0;
    @(negedge clk); #1 check("R11 powerdown hiz", int'(dataOutEn), 0);
    @(negedge clk); rpN = 1; ceN = 1; oeN = 1; verifyOk = 1; cyc(3);
    rdChk("R11 block invalid, array mode", 6'h31, 8'h00);
    wrCmd(0, 8'h70); rdChk("R11 status 80", 0, 8'h80);
    wrCmd(6'h30, 8'h20); wrCmd(6'h30, 8'hD0); cyc(3);
    wrCmd(0, 8'hFF); rdChk("R11 valid after erase", 6'h31, 8'hFF);

    cyc(2);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule